// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds a group of independent 32-bit down counters, each reached through its own 64-byte register window on a simple synchronous register bus (address, write data, write strobe, read strobe, read data). Each counter runs either from the system clock or from a 1 MHz tick strobe, reloads itself when it passes through zero, and can raise a sticky interrupt status bit that drives one interrupt line per channel.

Software never writes the control bits directly. It writes a set register to turn bits on and a clear register to turn bits off, so there is no read-modify-write race between channels or agents. The set and clear paths are staged. On a set, the configuration bits take effect first and the run bit follows one cycle later. On a clear, the run bit is dropped first and the configuration bits follow one cycle later. A counter therefore never runs with a half-updated configuration.

Top module: `tmr_bank`

## Requirements
- R1: The channel index is the bus address shifted right by 6 and the register is address bits [5:0]. An index of 8 or more reads as 0, and a write to such an index changes no state.
- R2: Register offsets 0x00 (counter value), 0x04 (reload value), 0x08 (first match) and 0x0C (second match) are each 32 bits wide. Each is writable and reads back the last value written, except that the counter also moves while it runs.
- R3: A write to offset 0x10 sets every control bit whose position in write-data bits [3:0] is 1 and leaves the others alone. The control bits are bit 0 run, bit 1 tick-clock select, bit 2 wrap interrupt enable and bit 3 pulse enable. Bit 16 of a set write never sets the interrupt status.
- R4: After a set write, the configuration bits (1..3) read back changed on the next cycle. The run bit reads back changed one cycle after that.
- R5: A write to offset 0x14 clears the run bit on the next cycle and clears the configuration bits given in write-data bits [3:1] one cycle after that. When write-data bit 16 is 1, it clears the channel's interrupt status.
- R6: A read of offset 0x10 returns the control bits in [3:0] and the interrupt status in bit 16, with all other bits 0. Reads of 0x14 or of any undefined offset return 0, and read data is 0 whenever the read strobe is low.
- R7: A running counter steps once per system clock when bit 1 is 0, or once per tick strobe when bit 1 is 1. A step decrements a nonzero value, and a step at zero loads the reload value and is a wrap.
- R8: A wrap with bit 2 set sets the interrupt status, and the channel's interrupt output equals that status. A wrap in the same cycle as a status-clear write leaves the status set.
- R9: A write to offset 0x00 loads the counter and overrides any step in the same cycle, and no wrap occurs in that cycle.
- R10: After reset, all registers, control bits, pending stages and status bits are 0, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the read strobe |
| tick_1us | input | 1 | One-cycle 1 MHz tick strobe |
| irq | output | N_TMR (8) | Per-channel interrupt lines |

## Verification
The counters are run with reload 0, which wraps on every cycle, with a short reload on the system clock, and with a short reload on a sparse tick strobe. These cases separate per-clock stepping from per-tick stepping and show whether the reload happens on the zero step or on the step before it. Control updates are read back in the cycles just after set and clear writes, single and back to back, so a design that applies the run bit together with the configuration bits is caught. Accesses to indices 8 and above, to undefined offsets and to the clear register, and set writes carrying bit 16, check that neighbouring state and the status are untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [5:0] OFS_CNT = 6'h00;
  localparam logic [5:0] OFS_RLD = 6'h04;
  localparam logic [5:0] OFS_MA  = 6'h08;
  localparam logic [5:0] OFS_MB  = 6'h0C;
  localparam logic [5:0] OFS_SET = 6'h10;
  localparam logic [5:0] OFS_CLR = 6'h14;
  localparam int STS_BIT = 16;

  // bit 0 run, bit 1 tick select, bit 2 wrap irq enable, bit 3 pulse enable
  typedef struct packed {
    logic pulse;
    logic wrap_ie;
    logic tick_sel;
    logic run;
  } ctrl_t;

  // Commit the staged half of the previous set/clear write.
  function automatic ctrl_t apply_stage(ctrl_t cur, logic run_pend, logic [2:0] cfg_pend);
    ctrl_t c;
    c          = cur;
    c.run      = c.run | run_pend;
    c.tick_sel = c.tick_sel & ~cfg_pend[0];
    c.wrap_ie  = c.wrap_ie  & ~cfg_pend[1];
    c.pulse    = c.pulse    & ~cfg_pend[2];
    return c;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_sel,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic          rld_wr,
  input  logic          ma_wr,
  input  logic          mb_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic [CW-1:0] ma_o,
  output logic [CW-1:0] mb_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, rld_q, ma_q, mb_q;
  logic          step;

  function automatic logic [CW-1:0] next_count(logic [CW-1:0] cur, logic [CW-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign step   = run && (tick_sel ? tick : 1'b1);
  assign wrap_o = step && !cnt_wr && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
    end else begin
      if (cnt_wr)    cnt_q <= wdata;
      else if (step) cnt_q <= next_count(cnt_q, rld_q);
      if (rld_wr) rld_q <= wdata;
      if (ma_wr)  ma_q  <= wdata;
      if (mb_wr)  mb_q  <= wdata;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ma_o  = ma_q;
  assign mb_o  = mb_q;

  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && cnt_q == '0) |=> cnt_q == $past(rld_q));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt_q));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wr,
  input  logic       clr_wr,
  input  logic [3:0] wr_bits,
  input  logic       sts_clr,
  input  logic       wrap_evt,
  output ctrl_t      ctrl_o,
  output logic       sts_o
);
  ctrl_t      ctrl_q, ctrl_d, staged;
  logic       run_pend_q, run_pend_d;
  logic [2:0] cfg_pend_q, cfg_pend_d;
  logic       sts_q, raise;

  assign raise = wrap_evt && ctrl_q.wrap_ie;

  always_comb begin
    staged     = apply_stage(ctrl_q, run_pend_q, cfg_pend_q);
    ctrl_d     = staged;
    run_pend_d = 1'b0;
    cfg_pend_d = '0;
    if (set_wr) begin
      ctrl_d.tick_sel = staged.tick_sel | wr_bits[1];
      ctrl_d.wrap_ie  = staged.wrap_ie  | wr_bits[2];
      ctrl_d.pulse    = staged.pulse    | wr_bits[3];
      run_pend_d      = wr_bits[0];
    end else if (clr_wr) begin
      ctrl_d.run = staged.run & ~wr_bits[0];
      cfg_pend_d = wr_bits[3:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      run_pend_q <= 1'b0;
      cfg_pend_q <= '0;
      sts_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      run_pend_q <= run_pend_d;
      cfg_pend_q <= cfg_pend_d;
      if (raise)        sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign sts_o  = sts_q;

  a_r4_run_after_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.run) |-> $past(run_pend_q));
  a_r4_run_not_with_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && wr_bits[0] && !ctrl_q.run && !run_pend_q) |=> !ctrl_q.run);
  a_r5_cfg_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.tick_sel) |-> $past(cfg_pend_q[0]));
  a_r5_run_drops_next: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_bits[0]) |=> !ctrl_q.run);
  a_r3_status_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(wrap_evt && ctrl_q.wrap_ie));
  a_r8_wrap_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && ctrl_q.wrap_ie && sts_clr) |=> sts_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1us,
  output logic [N_TMR-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 6;

  logic [IDX_W-1:0] idx;
  logic [5:0]       ofs;
  logic             idx_ok;

  logic [DATA_W-1:0] cnt_a [N_TMR];
  logic [DATA_W-1:0] rld_a [N_TMR];
  logic [DATA_W-1:0] ma_a  [N_TMR];
  logic [DATA_W-1:0] mb_a  [N_TMR];
  ctrl_t             ctrl_a[N_TMR];
  logic [N_TMR-1:0]  sts_a;
  logic [N_TMR-1:0]  wrap_a;

  assign idx    = bus_addr[ADDR_W-1:6];
  assign ofs    = bus_addr[5:0];
  assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(N_TMR));

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic hit_wr;
    assign hit_wr = bus_wr && idx_ok && (idx == IDX_W'(g));

    tmr_counter #(.CW(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_a[g].run),
      .tick_sel (ctrl_a[g].tick_sel),
      .tick     (tick_1us),
      .cnt_wr   (hit_wr && ofs == OFS_CNT),
      .rld_wr   (hit_wr && ofs == OFS_RLD),
      .ma_wr    (hit_wr && ofs == OFS_MA),
      .mb_wr    (hit_wr && ofs == OFS_MB),
      .wdata    (bus_wdata),
      .cnt_o    (cnt_a[g]),
      .rld_o    (rld_a[g]),
      .ma_o     (ma_a[g]),
      .mb_o     (mb_a[g]),
      .wrap_o   (wrap_a[g])
    );

    tmr_ctrl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wr   (hit_wr && ofs == OFS_SET),
      .clr_wr   (hit_wr && ofs == OFS_CLR),
      .wr_bits  (bus_wdata[3:0]),
      .sts_clr  (hit_wr && ofs == OFS_CLR && bus_wdata[STS_BIT]),
      .wrap_evt (wrap_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .sts_o    (sts_a[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && idx_ok) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (idx == IDX_W'(i)) begin
          case (ofs)
            OFS_CNT: bus_rdata = cnt_a[i];
            OFS_RLD: bus_rdata = rld_a[i];
            OFS_MA:  bus_rdata = ma_a[i];
            OFS_MB:  bus_rdata = mb_a[i];
            OFS_SET: begin
              bus_rdata[3:0]     = ctrl_a[i];
              bus_rdata[STS_BIT] = sts_a[i];
            end
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

  assign irq = sts_a;

  a_r6_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
  a_r1_far_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !idx_ok) |-> bus_rdata == '0);
  a_r6_clear_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == OFS_CLR) |-> bus_rdata == '0);
  a_r8_irq_needs_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap_a) != '0));
endmodule

// File: tb/test_tmr_bank.sv
`timescale 1ns/1ps
module test_tmr_bank;
  localparam int NT = 8;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          tick_1us = 1'b0;
  logic [NT-1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R10";

  tmr_bank #(.N_TMR(NT), .DATA_W(DW), .ADDR_W(AW)) i_tmr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_1us(tick_1us), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_1us <= (cyc % 7 == 3);
  end

  // Behavioural reference model
  logic [31:0] m_cnt [NT];
  logic [31:0] m_rld [NT];
  logic [31:0] m_ma  [NT];
  logic [31:0] m_mb  [NT];
  logic [3:0]  m_ctl [NT];
  logic        m_pen [NT];
  logic [2:0]  m_pcl [NT];
  logic        m_sts [NT];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_ma[i] = 0; m_mb[i] = 0;
        m_ctl[i] = 0; m_pen[i] = 0; m_pcl[i] = 0; m_sts[i] = 0;
      end
    end else begin
      for (int i = 0; i < NT; i++) begin
        logic sel; logic [5:0] o; logic [3:0] c; logic stp; logic wrp;
        sel = bus_wr && (int'(bus_addr >> 6) == i);
        o = bus_addr[5:0];
        c = m_ctl[i];
        stp = c[0] && (c[1] ? tick_1us : 1'b1);
        wrp = 1'b0;
        if (sel && o == 6'h00) m_cnt[i] = bus_wdata;
        else if (stp) begin
          if (m_cnt[i] == 0) begin m_cnt[i] = m_rld[i]; wrp = 1'b1; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
        if (sel && o == 6'h04) m_rld[i] = bus_wdata;
        if (sel && o == 6'h08) m_ma[i] = bus_wdata;
        if (sel && o == 6'h0C) m_mb[i] = bus_wdata;
        if (wrp && c[2]) m_sts[i] = 1'b1;
        else if (sel && o == 6'h14 && bus_wdata[16]) m_sts[i] = 1'b0;
        if (m_pen[i]) c[0] = 1'b1;
        c[3:1] = c[3:1] & ~m_pcl[i];
        m_pen[i] = 1'b0;
        m_pcl[i] = 3'b000;
        if (sel && o == 6'h10) begin
          c[3:1] = c[3:1] | bus_wdata[3:1];
          m_pen[i] = bus_wdata[0];
        end else if (sel && o == 6'h14) begin
          c[0] = c[0] & ~bus_wdata[0];
          m_pcl[i] = bus_wdata[3:1];
        end
        m_ctl[i] = c;
      end
    end
  end

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    int ix;
    logic [31:0] v;
    ix = int'(a >> 6);
    v = 0;
    if (ix < NT) begin
      case (a[5:0])
        6'h00: v = m_cnt[ix];
        6'h04: v = m_rld[ix];
        6'h08: v = m_ma[ix];
        6'h0C: v = m_mb[ix];
        6'h10: begin v[3:0] = m_ctl[ix]; v[16] = m_sts[ix]; end
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  task automatic compare();
    logic [NT-1:0] ei;
    logic [31:0] er;
    for (int i = 0; i < NT; i++) ei[i] = m_sts[i];
    er = bus_rd ? mread(bus_addr) : 32'h0;
    n_cmp++;
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL %s irq actual=%h expected=%h", cur_req, irq, ei);
    end
    n_cmp++;
    if (bus_rdata !== er) begin
      n_bad++;
      $display("FAIL %s rdata@%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, er);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic idle_rd(input logic [AW-1:0] a, input int n);
    for (int k = 0; k < n; k++) rd(a);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: every register of several channels reads zero after reset
    cur_req = "R10";
    for (int t = 0; t < NT; t += 3)
      for (int r = 0; r < 5; r++) rd(AW'(t * 64 + r * 4));
    // R2: plain register write and readback
    cur_req = "R2";
    for (int t = 0; t < NT; t++) begin
      wr(AW'(t * 64 + 4), 32'hA000_0000 + t);
      wr(AW'(t * 64 + 8), 32'h1234_5600 + t);
      wr(AW'(t * 64 + 12), 32'hFFFF_0000 - t);
      rd(AW'(t * 64 + 4)); rd(AW'(t * 64 + 8)); rd(AW'(t * 64 + 12));
    end
    // R3: set register, bit 16 must not raise status
    cur_req = "R3";
    wr(10'h090, 32'h0001_0008);
    rd(10'h090); rd(10'h090);
    // R4: configuration first, run one cycle later
    cur_req = "R4";
    wr(10'h000, 32'h0000_0003); wr(10'h004, 32'h0000_0003);
    wr(10'h010, 32'h0000_0005);
    idle_rd(10'h010, 3);
    // R7: system-clock counting with reload
    cur_req = "R7";
    idle_rd(10'h000, 12);
    // R8: status raised on wrap, clear, re-raise
    cur_req = "R8";
    rd(10'h010);
    wr(10'h014, 32'h0001_0000);
    idle_rd(10'h010, 6);
    // R7: tick-driven counting on channel 1
    cur_req = "R7";
    wr(10'h044, 32'h0000_0002); wr(10'h040, 32'h0000_0002);
    wr(10'h050, 32'h0000_0007);
    idle_rd(10'h040, 40);
    // R8: wrap every cycle beats a status clear
    cur_req = "R8";
    wr(10'h0C4, 32'h0); wr(10'h0C0, 32'h0);
    wr(10'h0D0, 32'h0000_0005);
    idle_rd(10'h0D0, 3);
    wr(10'h0D4, 32'h0001_0000);
    rd(10'h0D0);
    // R9: counter write during counting
    cur_req = "R9";
    wr(10'h000, 32'h0000_0100);
    rd(10'h000);
    wr(10'h000, 32'h0000_0000);
    idle_rd(10'h000, 3);
    // R5: clear run first, then configuration
    cur_req = "R5";
    wr(10'h014, 32'h0000_000F);
    idle_rd(10'h010, 3);
    wr(10'h054, 32'h0001_0002);
    idle_rd(10'h050, 3);
    // R4: back-to-back set then clear on the same channel
    cur_req = "R4";
    wr(10'h110, 32'h0000_000F);
    wr(10'h114, 32'h0000_0003);
    idle_rd(10'h110, 3);
    // R5: clear then immediate set
    cur_req = "R5";
    wr(10'h114, 32'h0000_000C);
    wr(10'h110, 32'h0000_0008);
    idle_rd(10'h110, 3);
    // R1: far index writes ignored, reads zero
    cur_req = "R1";
    wr(10'h200, 32'hDEAD_BEEF);
    wr(10'h210, 32'h0000_000F);
    wr(10'h3C4, 32'h5555_5555);
    rd(10'h200); rd(10'h3C4); rd(10'h000); rd(10'h004); rd(10'h1C4);
    // R6: clear register and undefined offsets read zero
    cur_req = "R6";
    wr(10'h018, 32'hFFFF_FFFF);
    wr(10'h03C, 32'hFFFF_FFFF);
    rd(10'h014); rd(10'h018); rd(10'h03C); rd(10'h0D0);
    for (int t = 0; t < NT; t++) rd(AW'(t * 64 + 16));
    idle_rd(10'h0C0, 4);
    cur_req = "R7";
    for (int k = 0; k < 60; k++) step();
    summary();
  end
endmodule